// File: doc/BRIEF.md
# Serial VID Command Receiver

This block is a receive-only slave on a two-wire serial bus. A processor uses it to set the voltage-identification (VID) code and the power-save hint for up to three supply rails. Each write is one send-byte transaction: a start condition, a 7-bit address, a write bit, an acknowledge slot, one data byte, a second acknowledge slot, and a stop condition. The address is not a single slave identity. It is a fixed 3-bit prefix, one reserved bit, and one select bit per rail, so one write can target any mix of rails.

Both bus lines are sampled by the system clock through synchronizers. Start and stop conditions and clock edges are found in the synchronized domain. The block acknowledges by requesting a pull-low on the open-drain data line. A write that completes cleanly is committed only when its stop condition arrives. The selected rails then take the new code, and each one raises a one-cycle update strobe.

Top module: `svid_cmd_rx`

## Requirements
- R1: A start is data falling while clock is high, and a stop is data rising while clock is high. A start at any point in a transaction restarts reception at the first address bit.
- R2: The address phase is acknowledged only if address bits 6..4 equal 3'b110, the write bit (the eighth bit on the wire) is 0, and at least one of address bits 2..0 is 1. Address bit 3 has no effect on this decision.
- R3: The acknowledge pull-low (`sda_pull_o` = 1) begins at the clock fall that ends the eighth bit of a byte and ends at the clock fall that ends the ninth bit. At all other times `sda_pull_o` is 0.
- R4: Both bytes are received most significant bit first. Data bit 7 is the power-save flag and data bits 6..0 are the VID code.
- R5: Address bit 0 selects rail 0 (northbridge), bit 1 selects rail 1 (VDD0), and bit 2 selects rail 2 (VDD1). Rail i uses `vid_o[7*i +: 7]`, `psi_o[i]` and `upd_o[i]`. Every selected rail takes the same data byte.
- R6: After an acknowledged address, every data byte value is acknowledged.
- R7: Rail outputs change only when a stop condition follows a fully acknowledged transaction. The matching `upd_o` bits are high for exactly one system clock cycle.
- R8: Rail outputs do not change after a rejected address, a read bit, or a transaction that is cut short by a new start before its stop.
- R9: After reset, every rail holds VID 0 with the power-save flag at 1, and `upd_o` and `sda_pull_o` are 0.
- R10: Rails whose select bit is 0 keep their VID and flag through a committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin, including this block's own pull |
| sda_pull_o | output | 1 | 1 requests the open-drain data line to be pulled low |
| vid_o | output | 21 | VID code per rail, 7 bits each, rail 0 in the low bits |
| psi_o | output | 3 | Power-save flag per rail |
| upd_o | output | 3 | One-cycle strobe per rail when its command is committed |

## Verification
The assertions check four things on every cycle:
- an update strobe only ever follows a detected stop, and it lasts one cycle;
- rail values never move without a strobe;
- the acknowledge pull only toggles on a synchronized clock fall or a bus condition.

Only the bench scenarios can show the decoding itself: which address patterns earn an acknowledge, which rails a select mask reaches, and that the VID does not appear before the stop. The same holds for how aborted transactions are abandoned, a read bit, a repeated start without a stop, or a start in the middle of an address.

// File: rtl/svid_pkg.sv
package svid_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_WSTOP
  } svid_st_e;
endpackage

// File: rtl/svid_bus_sync.sv
module svid_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;
  logic scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = !scl_p && scl_s;
  assign scl_fall  = scl_p && !scl_s;
  // data edges only count while the clock stays high across both samples
  assign start_det = scl_p && scl_s && sda_p && !sda_s;
  assign stop_det  = scl_p && scl_s && !sda_p && sda_s;
endmodule

// File: rtl/svid_frame_fsm.sv
module svid_frame_fsm
  import svid_pkg::*;
#(
  parameter int          NRAIL  = 3,
  parameter logic [2:0]  PREFIX = 3'b110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_pull,
  output logic              addr_ok,
  output logic              commit,
  output logic [NRAIL-1:0]  sel,
  output logic [BYTE_W-1:0] data
);
  localparam int PFX_W = ADDR_W - 1 - NRAIL;
  localparam int CNT_W = $clog2(BYTE_W + 1);

  svid_st_e           state;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  sh;
  logic               byte_full;

  // Address byte as shifted: [7 -: PFX_W] prefix, [NRAIL+1] reserved,
  // [NRAIL:1] rail selects, [0] read/write.
  function automatic logic addr_accept(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: PFX_W] == PREFIX[PFX_W-1:0]) && !b[0] && (|b[NRAIL:1]);
  endfunction

  assign byte_full = (cnt == CNT_W'(BYTE_W));
  assign addr_ok   = addr_accept(sh);
  assign commit    = stop_det && (state == ST_WSTOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_pull <= 1'b0;
      sel      <= '0;
      data     <= '0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_DATA: begin
          if (scl_rise && !byte_full) begin
            sh  <= {sh[BYTE_W-2:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && byte_full) begin
            if (state == ST_DATA) begin
              data     <= sh;
              sda_pull <= 1'b1;
              state    <= ST_DACK;
            end else if (addr_ok) begin
              sel      <= sh[NRAIL:1];
              sda_pull <= 1'b1;
              state    <= ST_AACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_AACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          cnt      <= '0;
          state    <= ST_DATA;
        end
        ST_DACK: if (scl_fall) begin
          sda_pull <= 1'b0;
          state    <= ST_WSTOP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/svid_rail_bank.sv
module svid_rail_bank #(
  parameter int               NRAIL     = 3,
  parameter int               VID_W     = 7,
  parameter logic [VID_W-1:0] RESET_VID = '0,
  parameter logic             RESET_PSI = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [NRAIL-1:0]       sel,
  input  logic [VID_W:0]         data,
  output logic [NRAIL*VID_W-1:0] vid_o,
  output logic [NRAIL-1:0]       psi_o,
  output logic [NRAIL-1:0]       upd_o
);
  for (genvar i = 0; i < NRAIL; i++) begin : g_rail
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vid_o[i*VID_W +: VID_W] <= RESET_VID;
        psi_o[i]                <= RESET_PSI;
        upd_o[i]                <= 1'b0;
      end else begin
        upd_o[i] <= commit && sel[i];
        if (commit && sel[i]) begin
          vid_o[i*VID_W +: VID_W] <= data[VID_W-1:0];
          psi_o[i]                <= data[VID_W];
        end
      end
    end
  end
endmodule

// File: rtl/svid_cmd_rx.sv
module svid_cmd_rx #(
  parameter int               NRAIL       = 3,
  parameter int               VID_W       = 7,
  parameter int               SYNC_STAGES = 2,
  parameter logic [2:0]       PREFIX      = 3'b110,
  parameter logic [VID_W-1:0] RESET_VID   = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_pull_o,
  output logic [NRAIL*VID_W-1:0] vid_o,
  output logic [NRAIL-1:0]       psi_o,
  output logic [NRAIL-1:0]       upd_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_ok, commit;
  logic [NRAIL-1:0] sel;
  logic [VID_W:0]   data;

  svid_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  svid_frame_fsm #(.NRAIL(NRAIL), .PREFIX(PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_pull(sda_pull_o), .addr_ok(addr_ok), .commit(commit),
    .sel(sel), .data(data)
  );

  svid_rail_bank #(.NRAIL(NRAIL), .VID_W(VID_W), .RESET_VID(RESET_VID), .RESET_PSI(1'b1)) u_bank (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sel(sel), .data(data),
    .vid_o(vid_o), .psi_o(psi_o), .upd_o(upd_o)
  );
endmodule

// File: rtl/svid_cmd_rx_chk.sv
module svid_cmd_rx_chk #(
  parameter int NRAIL = 3,
  parameter int VID_W = 7
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_fall,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   sda_pull_o,
  input logic [NRAIL*VID_W-1:0] vid_o,
  input logic [NRAIL-1:0]       psi_o,
  input logic [NRAIL-1:0]       upd_o
);
  // R7
  upd_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |-> $past(stop_det));

  // R7
  upd_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd_o) |=> (upd_o == '0));

  // R10
  rail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o == '0) |-> ($stable(vid_o) && $stable(psi_o)));

  // R3
  pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind svid_cmd_rx svid_cmd_rx_chk #(.NRAIL(NRAIL), .VID_W(VID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .sda_pull_o(sda_pull_o), .vid_o(vid_o),
  .psi_o(psi_o), .upd_o(upd_o)
);

// File: tb/svid_cmd_rx_tb.sv
module svid_cmd_rx_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull_o;
  logic [20:0] vid_o;
  logic [2:0]  psi_o, upd_o;
  wire  sda_line = sda_m & ~sda_pull_o;

  int total = 0, bad = 0;
  int upd_cnt = 0;
  logic [2:0] upd_mask = '0;
  logic [6:0] exp_vid [3];
  logic       exp_psi [3];

  always #10 clk = ~clk;

  svid_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .vid_o(vid_o), .psi_o(psi_o), .upd_o(upd_o)
  );

  always @(negedge clk) if (rst_n && (|upd_o)) begin
    upd_cnt  <= upd_cnt + 1;
    upd_mask <= upd_mask | upd_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic check_rails(input string req);
    for (int i = 0; i < 3; i++) begin
      chk(vid_o[i*7 +: 7] == exp_vid[i], req, vid_o[i*7 +: 7], exp_vid[i]);
      chk(psi_o[i] == exp_psi[i], req, psi_o[i], exp_psi[i]);
    end
  endtask

  task automatic clr_upd();
    @(negedge clk);
    upd_cnt  = 0;
    upd_mask = '0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic pre, post;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq();
    pre = sda_pull_o;
    scl_m = 1'b1; wq();
    ack = !sda_line;
    wq(); scl_m = 1'b0; wq();
    post = sda_pull_o;
    // R3: pull present before ninth rise iff acknowledged, gone after ninth fall
    chk(pre == ack, "R3 pull before ninth bit", pre, ack);
    chk(post == 1'b0, "R3 pull released", post, 0);
  endtask

  task automatic xfer(input logic [6:0] addr, input logic rw, input logic [7:0] data,
                      input bit do_stop, output logic a1, output logic a2);
    bus_start();
    send_byte({addr, rw}, a1);
    send_byte(data, a2);
    if (do_stop) bus_stop();
  endtask

  task automatic apply(input logic [2:0] sel, input logic [7:0] d);
    for (int i = 0; i < 3; i++) if (sel[i]) begin
      exp_vid[i] = d[6:0];
      exp_psi[i] = d[7];
    end
  endtask

  task automatic t_reset();
    check_rails("R9 reset rails");
    chk(upd_o == 3'b000, "R9 reset upd", upd_o, 0);
    chk(sda_pull_o == 1'b0, "R9 reset pull", sda_pull_o, 0);
  endtask

  task automatic t_single_vdd0();
    logic a1, a2;
    clr_upd();
    xfer(7'b110_0010, 1'b0, 8'h35, 0, a1, a2);
    chk(a1, "R2 address ack", a1, 1);
    chk(a2, "R6 data ack", a2, 1);
    check_rails("R7 no change before stop");
    chk(upd_cnt == 0, "R7 no strobe before stop", upd_cnt, 0);
    bus_stop();
    apply(3'b010, 8'h35);
    check_rails("R4 R5 R10 single rail VDD0");
    chk(upd_mask == 3'b010, "R5 strobe mask", upd_mask, 3'b010);
    chk(upd_cnt == 1, "R7 one strobe cycle", upd_cnt, 1);
  endtask

  task automatic t_all_reserved();
    logic a1, a2;
    clr_upd();
    xfer(7'b110_1111, 1'b0, 8'hAA, 1, a1, a2);
    chk(a1, "R2 reserved bit ignored", a1, 1);
    chk(a2, "R6 data ack", a2, 1);
    apply(3'b111, 8'hAA);
    check_rails("R4 R5 all rails");
    chk(upd_mask == 3'b111, "R5 all strobes", upd_mask, 3'b111);
  endtask

  task automatic t_nb_vdd1();
    logic a1, a2;
    clr_upd();
    xfer(7'b110_0101, 1'b0, 8'h13, 1, a1, a2);
    apply(3'b101, 8'h13);
    check_rails("R5 R10 NB and VDD1");
    chk(upd_mask == 3'b101, "R5 mask NB VDD1", upd_mask, 3'b101);
    chk(a2, "R6 data ack psi 0", a2, 1);
  endtask

  task automatic t_rejects();
    logic a1, a2;
    clr_upd();
    xfer(7'b101_0010, 1'b0, 8'h7F, 1, a1, a2);
    chk(!a1, "R2 bad prefix nack", a1, 0);
    xfer(7'b110_0010, 1'b1, 8'h7F, 1, a1, a2);
    chk(!a1, "R2 read bit nack", a1, 0);
    xfer(7'b110_1000, 1'b0, 8'h7F, 1, a1, a2);
    chk(!a1, "R2 empty select nack", a1, 0);
    check_rails("R8 rejected unchanged");
    chk(upd_cnt == 0, "R8 no strobe", upd_cnt, 0);
  endtask

  task automatic t_restart();
    logic a1, a2;
    clr_upd();
    xfer(7'b110_0111, 1'b0, 8'h55, 0, a1, a2);
    xfer(7'b110_0001, 1'b0, 8'h0C, 1, a1, a2);
    apply(3'b001, 8'h0C);
    check_rails("R8 R1 repeated start drops first write");
    chk(upd_cnt == 1 && upd_mask == 3'b001, "R8 only second commits", upd_mask, 3'b001);
  endtask

  task automatic t_mid_addr_start();
    logic a1, a2;
    clr_upd();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    xfer(7'b110_0010, 1'b0, 8'hC4, 1, a1, a2);
    chk(a1, "R1 restart address ack", a1, 1);
    apply(3'b010, 8'hC4);
    check_rails("R1 restart mid address");
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin exp_vid[i] = '0; exp_psi[i] = 1'b1; end
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single_vdd0();
    t_all_reserved();
    t_nb_vdd1();
    t_rejects();
    t_restart();
    t_mid_addr_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule